// File: doc/BRIEF.md
# Glitch-free clock switch

This block picks one of two clock sources and drives it onto a single output clock. The sources may run at unrelated frequencies and have no phase relation to each other. The select input may change at any time. The block hands over from one clock to the other without a glitch: no output high or low phase is ever shorter than the shortest phase of either input.

Each source has its own enable leg. A leg samples its request, together with the inverse of the other leg's enable, on the rising edges of its own clock. It then moves its enable on a falling edge of that clock. The output is the OR of the two gated clocks. The cross-coupling means a leg turns on only after the other leg has turned off, so during a switch the output stays low from the last falling edge of the old clock until the first full cycle of the new one.

A build parameter turns the block into a clock gate. Leg 0 then passes clock A while the select is high and holds the output low while it is low, with the same hand-over path and the same glitch-free behaviour.

Top module: `clk_switch`

## Requirements
- R1: Once a hand-over has finished, `sel` = 0 drives `clk_a` onto `clk_out` and `sel` = 1 drives `clk_b`. The output period equals the period of the selected input.
- R2: The two leg enables are never high at the same time, and an enable changes only while its own clock is low. After a hand-over, the output high time equals the high time of the selected input, so the other clock adds nothing.
- R3: Every high phase and every low phase of `clk_out` lasts at least as long as the shortest phase of either input. This holds for all frequency ratios and for select toggles at random times.
- R4: A hand-over finishes within (SYNC_STAGES+2) periods of the old clock plus (SYNC_STAGES+2) periods of the new clock. Until then the output stays low. The select must be held for at least that long between toggles.
- R5: If the newly selected clock is stopped, the output stays low and shows no partial pulse. Selecting the still-running old clock again restores it normally.
- R6: While `rst` is high, leg A is enabled and leg B is disabled, so `clk_out` follows `clk_a`. Each leg leaves reset synchronously to its own clock, after RST_STAGES rising edges.
- R7: With GATE_ONLY = 1, `sel` = 0 holds `clk_out` low and `sel` = 1 passes `clk_a` with its own period and high time. `clk_b` is never used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Clock source chosen when sel is 0 (the gated clock when GATE_ONLY = 1) |
| clk_b | input | 1 | Clock source chosen when sel is 1 (unused when GATE_ONLY = 1) |
| sel | input | 1 | Source select, or the enable in gate mode |
| rst | input | 1 | Active-high reset, asserted asynchronously and released per clock domain |
| clk_out | output | 1 | Switched or gated output clock |

## Verification
A select change becomes visible at the output only after the old leg's synchronizer and its falling-edge flop, followed by the new leg's synchronizer and its falling-edge flop. That path is bounded by (SYNC_STAGES+2) periods of each clock. After every select change, the bench waits out that bound, computed from the current half periods, before it measures the output period and high time edge to edge. A separate monitor timestamps every output edge for the whole run. It compares the shortest high and low phase it has seen against the shortest input phase applied, so phases cut short during a hand-over are caught however they line up. The stopped-clock and gate checks count output rising edges over a window that opens only after the same bound.

// File: rtl/clk_switch_pkg.sv
`timescale 1ps/1ps
package clk_switch_pkg;

    localparam int NUM_SRC = 2;

    typedef enum logic {
        SRC_A = 1'b0,
        SRC_B = 1'b1
    } src_e;

    // Request level for one leg, given the select and the build mode.
    function automatic logic leg_wants(input logic sel, input int unsigned leg, input bit gate_only);
        src_e pick;
        pick = src_e'(sel);
        if (gate_only) begin
            return (leg == 0) ? sel : 1'b0;
        end
        return (leg == 0) ? (pick == SRC_A) : (pick == SRC_B);
    endfunction

    // Enable level a leg holds while its reset is active.
    function automatic logic leg_reset_state(input int unsigned leg, input bit gate_only);
        return (leg == 0) && !gate_only;
    endfunction

endpackage

// File: rtl/clk_switch_rst_sync.sv
`timescale 1ps/1ps
module clk_switch_rst_sync #(
    parameter int RST_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic rst_o
);

    logic [RST_STAGES-1:0] hold_q;

    // Reset is asserted at once and released on this domain's rising edges.
    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            hold_q <= '1;
        end else begin
            hold_q <= RST_STAGES'({hold_q, 1'b0});
        end
    end

    assign rst_o = hold_q[RST_STAGES-1];

endmodule

// File: rtl/clk_switch_leg.sv
`timescale 1ps/1ps
module clk_switch_leg #(
    parameter int   SYNC_STAGES = 2,
    parameter logic EN_AT_RESET = 1'b0
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic want_i,
    input  logic peer_en_i,
    output logic en_o
);

    logic [SYNC_STAGES-1:0] req_q;
    logic                   en_q;
    logic                   take;

    // This leg may turn on only while the peer's enable is seen low.
    assign take = want_i & ~peer_en_i;

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            req_q <= {SYNC_STAGES{EN_AT_RESET}};
        end else begin
            req_q <= SYNC_STAGES'({req_q, take});
        end
    end

    // The enable moves on the falling edge, so the gated clock never sees a cut.
    always_ff @(negedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            en_q <= EN_AT_RESET;
        end else begin
            en_q <= req_q[SYNC_STAGES-1];
        end
    end

    assign en_o = en_q;

    // R2: outside reset the enable moves only while its clock is low
    always @(en_q) begin
        if (!rst_i) begin
            a_r2_enable_moves_low: assert (clk_i == 1'b0)
                else $error("enable changed while its clock was high");
        end
    end

endmodule

// File: rtl/clk_switch.sv
`timescale 1ps/1ps
module clk_switch
    import clk_switch_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RST_STAGES  = 2,
    parameter bit GATE_ONLY   = 1'b0
) (
    input  logic clk_a,
    input  logic clk_b,
    input  logic sel,
    input  logic rst,
    output logic clk_out
);

    logic [NUM_SRC-1:0] clk_vec;
    logic [NUM_SRC-1:0] rst_vec;
    logic [NUM_SRC-1:0] want_vec;
    logic [NUM_SRC-1:0] en_vec;
    logic [NUM_SRC-1:0] gated;

    assign clk_vec = {clk_b, clk_a};

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_leg
        clk_switch_rst_sync #(
            .RST_STAGES(RST_STAGES)
        ) u_rst (
            .clk_i (clk_vec[g]),
            .rst_i (rst),
            .rst_o (rst_vec[g])
        );

        assign want_vec[g] = leg_wants(sel, g, GATE_ONLY);

        clk_switch_leg #(
            .SYNC_STAGES(SYNC_STAGES),
            .EN_AT_RESET(leg_reset_state(g, GATE_ONLY))
        ) u_leg (
            .clk_i     (clk_vec[g]),
            .rst_i     (rst_vec[g]),
            .want_i    (want_vec[g]),
            .peer_en_i (en_vec[NUM_SRC-1-g]),
            .en_o      (en_vec[g])
        );

        assign gated[g] = clk_vec[g] & en_vec[g];
    end

    assign clk_out = |gated;

    // R2: the legs never own the output together (seen from either clock)
    a_r2_one_leg_clka: assert property (@(posedge clk_a) disable iff (rst_vec[0])
        !(en_vec[0] && en_vec[1]));

    a_r2_one_leg_clkb: assert property (@(posedge clk_b) disable iff (rst_vec[1])
        !(en_vec[0] && en_vec[1]));

    // R1: a rising output edge always comes from an enabled leg
    always @(posedge clk_out) begin
        if (!rst) begin
            a_r1_rise_needs_enable: assert (en_vec[0] || en_vec[1])
                else $error("output rose with no leg enabled");
        end
    end

endmodule

// File: tb/tb_clk_switch.sv
`timescale 1ps/1ps
module tb_clk_switch;

    localparam int SYNC = 2;
    localparam int NV   = 7;

    typedef struct packed {
        int   ha;
        int   hb;
        logic sel;
        int   exp_per;
        int   exp_hi;
    } vec_t;

    // Half periods in ps, select, expected output period and high time.
    localparam vec_t VECS [NV] = '{
        '{5000, 3000, 1'b1,  6000, 3000},
        '{5000, 3000, 1'b0, 10000, 5000},
        '{2000, 7000, 1'b1, 14000, 7000},
        '{2000, 7000, 1'b0,  4000, 2000},
        '{4100, 4300, 1'b1,  8600, 4300},
        '{9000, 1300, 1'b0, 18000, 9000},
        '{9000, 1300, 1'b1,  2600, 1300}
    };

    logic tb_clk = 1'b0;
    logic clk_a  = 1'b0;
    logic clk_b  = 1'b0;
    logic sel    = 1'b0;
    logic sel_g  = 1'b0;
    logic rst    = 1'b1;
    logic clk_out;
    logic clk_gated;

    int   half_a = 5000;
    int   half_b = 3000;
    bit   b_run  = 1'b1;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    clk_switch #(.SYNC_STAGES(SYNC), .RST_STAGES(2), .GATE_ONLY(1'b0)) dut (
        .clk_a(clk_a), .clk_b(clk_b), .sel(sel), .rst(rst), .clk_out(clk_out));

    clk_switch #(.SYNC_STAGES(SYNC), .RST_STAGES(2), .GATE_ONLY(1'b1)) dut_gate (
        .clk_a(clk_a), .clk_b(clk_b), .sel(sel_g), .rst(rst), .clk_out(clk_gated));

    initial forever #2000 tb_clk = ~tb_clk;
    initial forever begin #(half_a); clk_a = ~clk_a; end
    initial forever begin #(half_b); clk_b = b_run ? ~clk_b : 1'b0; end

    // Output phase monitor
    bit     mon_on    = 1'b0;
    bit     have_edge = 1'b0;
    longint last_edge = 0;
    longint min_hi    = 64'd1 << 40;
    longint min_lo    = 64'd1 << 40;
    longint min_in    = 64'd1 << 40;
    int     rise_out  = 0;
    int     rise_gate = 0;

    always @(clk_out) begin
        if (mon_on && have_edge) begin
            if (clk_out) begin
                if ($time - last_edge < min_lo) min_lo = $time - last_edge;
            end else begin
                if ($time - last_edge < min_hi) min_hi = $time - last_edge;
            end
        end
        last_edge = $time;
        have_edge = mon_on;
    end

    always @(posedge clk_out)   rise_out++;
    always @(posedge clk_gated) rise_gate++;

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_clocks(input int ha, input int hb);
        half_a = ha;
        half_b = hb;
        if (ha < min_in) min_in = ha;
        if (hb < min_in) min_in = hb;
        #(4 * (ha + hb));
    endtask

    function automatic int settle_ps(input int ha, input int hb);
        return (SYNC + 2) * 2 * (ha + hb);
    endfunction

    task automatic measure_out(output longint hi, output longint per);
        longint t1;
        longint t2;
        @(posedge clk_out) t1 = $time;
        @(negedge clk_out) t2 = $time;
        hi = t2 - t1;
        @(posedge clk_out) per = $time - t1;
    endtask

    task automatic measure_gate(output longint hi, output longint per);
        longint t1;
        longint t2;
        @(posedge clk_gated) t1 = $time;
        @(negedge clk_gated) t2 = $time;
        hi = t2 - t1;
        @(posedge clk_gated) per = $time - t1;
    endtask

    // Watchdog
    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge tb_clk);
            cyc++;
            if (cyc > 150000 && !done) begin
                check(1'b0, "WATCHDOG", "run did not finish", cyc, 150000);
                report();
                $finish;
            end
        end
    end

    initial begin
        longint hi;
        longint per;
        int     rc;

        min_in = 5000;
        if (half_b < min_in) min_in = half_b;

        // R6: reset enables leg A
        #60000;
        measure_out(hi, per);
        check(per == 10000, "R6", "period during reset", per, 10000);
        rst = 1'b0;
        #40000;
        measure_out(hi, per);
        check(per == 10000 && hi == 5000, "R6", "period after release", per, 10000);
        mon_on = 1'b1;

        // Table walk: R1 period, R2 high time, R4 settle bound
        for (int i = 0; i < NV; i++) begin
            set_clocks(VECS[i].ha, VECS[i].hb);
            sel = VECS[i].sel;
            #(settle_ps(VECS[i].ha, VECS[i].hb));
            measure_out(hi, per);
            check(per == VECS[i].exp_per, "R1 R4", $sformatf("vector %0d period", i),
                  per, VECS[i].exp_per);
            check(hi == VECS[i].exp_hi, "R2", $sformatf("vector %0d high time", i),
                  hi, VECS[i].exp_hi);
        end
        check(min_hi >= min_in, "R3", "shortest high phase over table", min_hi, min_in);
        check(min_lo >= min_in, "R3", "shortest low phase over table", min_lo, min_in);

        // R5: switch toward a stopped clock, then come back
        set_clocks(5000, 3000);
        sel = 1'b0;
        #(settle_ps(5000, 3000));
        b_run = 1'b0;
        #20000;
        sel = 1'b1;
        #(settle_ps(5000, 3000));
        rc = rise_out;
        #200000;
        check(rise_out == rc, "R5", "rising edges with stopped clock", rise_out - rc, 0);
        check(clk_out == 1'b0, "R5", "output level with stopped clock", clk_out, 0);
        sel = 1'b0;
        #(settle_ps(5000, 3000));
        measure_out(hi, per);
        check(per == 10000, "R5", "period after returning to running clock", per, 10000);
        b_run = 1'b1;
        #20000;

        // R3: random select toggles, asynchronous clocks
        set_clocks(3700, 2300);
        for (int k = 0; k < 120; k++) begin
            int s;
            s = settle_ps(3700, 2300);
            #(s + int'($urandom % s));
            sel = ~sel;
        end
        #(settle_ps(3700, 2300));
        measure_out(hi, per);
        check(per == (sel ? 4600 : 7400), "R1", "period after random toggles",
              per, sel ? 4600 : 7400);
        check(min_hi >= min_in, "R3", "shortest high phase overall", min_hi, min_in);
        check(min_lo >= min_in, "R3", "shortest low phase overall", min_lo, min_in);

        // R7: gate variant
        set_clocks(5000, 3000);
        rc = rise_gate;
        #100000;
        check(rise_gate == rc, "R7", "gate closed rising edges", rise_gate - rc, 0);
        sel_g = 1'b1;
        #(settle_ps(5000, 3000));
        measure_gate(hi, per);
        check(per == 10000 && hi == 5000, "R7", "gate open period", per, 10000);
        sel_g = 1'b0;
        #(settle_ps(5000, 3000));
        rc = rise_gate;
        #100000;
        check(rise_gate == rc, "R7", "gate closed again", rise_gate - rc, 0);

        done = 1'b1;
        report();
        $finish;
    end

endmodule